// File: doc/BRIEF.md
# DDR2 Burst Write Sequencer

This block turns a single 128-bit write request from a client into the command-level handshake that a DDR2 memory controller expects. The controller moves one 64-bit beat per clock, so each request becomes a two-beat burst. The block waits until the memory is usable before it accepts a request. The memory must report initialization complete, no other command may be running on the shared command bus, and no refresh may be pending. On acceptance the block registers the address and the 128-bit word. It asserts the write command and holds it until the controller acknowledges.

Two state machines share the work. The control machine runs the command, acknowledge, beat-wait and burst-done phases. The data-feed machine starts on the acknowledge and presents the low half of the word and then the high half. After the burst-done pair, the block holds a completion indication until the client drops its request. Only then does it go idle and accept new work. A busy output spans the whole operation. A read sequencer on the same command bus uses it to stay off the bus.

Top module: `burstWriteSeq`

## Requirements
- R1: After a synchronous active-high reset, busy, done, memWrCmd and memBurstDone are 0, and memWrData is all zeros.
- R2: A request is taken only in a cycle where reqValid=1, memInitDone=1, memCmdBusy=0 and memRefreshPending=0. While any of these conditions fails, the request waits: busy and memWrCmd stay 0.
- R3: The cycle after acceptance, memWrCmd is 1 and memAddr shows the accepted address. memWrCmd stays 1 for as long as memWrAck remains 0.
- R4: Once memWrAck=1 is seen with the command asserted, the block spends the next two cycles in a wait phase with memWrCmd still 1. In the first of these cycles memWrData carries bits [63:0] of the accepted word, and in the second it carries bits [127:64].
- R5: Right after the two beat cycles, memBurstDone is 1 for exactly two cycles, and memWrCmd is 0 during both of them.
- R6: After the burst-done pair, done is 1 and remains 1 while reqValid stays 1. One cycle after reqValid falls, done and busy are 0.
- R7: busy is 1 from the cycle after acceptance until the return to idle. A new request is accepted only after busy has been seen 0.
- R8: The accepted address and data are registered. Changing reqAddr or reqData after acceptance has no effect on memAddr or on the beats driven.
- R9: memWrData is all zeros in every cycle other than the two beat cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Client write request level, held until done |
| reqAddr | input | ADDR_W | Client write address |
| reqData | input | 2*BEAT_W | Client 128-bit write word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Burst complete, waiting for request release |
| memInitDone | input | 1 | Memory initialization complete |
| memCmdBusy | input | 1 | Another command occupies the command bus |
| memRefreshPending | input | 1 | A refresh must run first |
| memWrCmd | output | 1 | Write command to the controller |
| memAddr | output | ADDR_W | Registered write address |
| memWrAck | input | 1 | Controller acknowledge of the write command |
| memBurstDone | output | 1 | End-of-burst indication |
| memWrData | output | BEAT_W | 64-bit data beat |

## Verification
The assertions assume that the client holds reqValid from the request until it sees done. They also assume that memWrAck rises only while the write command is pending and lasts one cycle. Under these conditions the command, burst-done and busy windows follow a fixed cycle order. The directed stimulus keeps to these rules. It changes inputs only at the falling edge, pulses the acknowledge for one cycle while the command is up, and drops the request only after observing done. Within those rules it changes the gating inputs, the acknowledge delay, the length of the end hold and the client's address and data after acceptance.

// File: rtl/burstWritePkg.sv
package burstWritePkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_ISSUE,
    CS_BEAT1,
    CS_BEAT2,
    CS_FIN1,
    CS_FIN2,
    CS_END
  } ctlState_t;

  typedef enum logic [1:0] {
    FD_IDLE,
    FD_LOW,
    FD_HIGH,
    FD_WAIT
  } feedState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch address and word
    logic feedStart;  // acknowledge seen while command pending
    logic reqGone;    // client request withdrawn
  } ctlStrobe_t;

endpackage

// File: rtl/burstWriteCtrl.sv
module burstWriteCtrl
  import burstWritePkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       memInitDone,
  input  logic       memCmdBusy,
  input  logic       memRefreshPending,
  input  logic       memWrAck,
  output logic       memWrCmd,
  output logic       memBurstDone,
  output logic       busy,
  output logic       done,
  output ctlStrobe_t strobe
);

  ctlState_t state, stateNext;
  logic memReady;

  assign memReady = memInitDone && !memCmdBusy && !memRefreshPending;

  always_comb begin
    stateNext = state;
    unique case (state)
      CS_IDLE:  if (reqValid && memReady) stateNext = CS_ISSUE;
      CS_ISSUE: if (memWrAck) stateNext = CS_BEAT1;
      CS_BEAT1: stateNext = CS_BEAT2;
      CS_BEAT2: stateNext = CS_FIN1;
      CS_FIN1:  stateNext = CS_FIN2;
      CS_FIN2:  stateNext = CS_END;
      CS_END:   if (!reqValid) stateNext = CS_IDLE;
      default:  stateNext = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= CS_IDLE;
    else     state <= stateNext;
  end

  assign memWrCmd     = (state == CS_ISSUE) || (state == CS_BEAT1) || (state == CS_BEAT2);
  assign memBurstDone = (state == CS_FIN1) || (state == CS_FIN2);
  assign busy         = (state != CS_IDLE);
  assign done         = (state == CS_END);

  assign strobe.capture   = (state == CS_IDLE) && reqValid && memReady;
  assign strobe.feedStart = (state == CS_ISSUE) && memWrAck;
  assign strobe.reqGone   = !reqValid;

endmodule

// File: rtl/burstWriteData.sv
module burstWriteData
  import burstWritePkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int BEAT_W = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctlStrobe_t            strobe,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [2*BEAT_W-1:0]   reqData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [BEAT_W-1:0]     memWrData
);

  localparam int NUM_BEATS = 2;

  feedState_t feedState, feedNext;
  logic [ADDR_W-1:0] addrReg;
  logic [BEAT_W-1:0] halfReg [NUM_BEATS];

  // capture registers, one per half
  for (genvar b = 0; b < NUM_BEATS; b++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst)                 halfReg[b] <= '0;
      else if (strobe.capture) halfReg[b] <= reqData[b*BEAT_W +: BEAT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 addrReg <= '0;
    else if (strobe.capture) addrReg <= reqAddr;
  end

  always_comb begin
    feedNext = feedState;
    unique case (feedState)
      FD_IDLE: if (strobe.feedStart) feedNext = FD_LOW;
      FD_LOW:  feedNext = FD_HIGH;
      FD_HIGH: feedNext = FD_WAIT;
      FD_WAIT: if (strobe.reqGone) feedNext = FD_IDLE;
      default: feedNext = FD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) feedState <= FD_IDLE;
    else     feedState <= feedNext;
  end

  always_comb begin
    unique case (feedState)
      FD_LOW:  memWrData = halfReg[0];
      FD_HIGH: memWrData = halfReg[1];
      default: memWrData = '0;
    endcase
  end

  assign memAddr = addrReg;

endmodule

// File: rtl/burstWriteSeq.sv
module burstWriteSeq
  import burstWritePkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int BEAT_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*BEAT_W-1:0] reqData,
  output logic                busy,
  output logic                done,
  input  logic                memInitDone,
  input  logic                memCmdBusy,
  input  logic                memRefreshPending,
  output logic                memWrCmd,
  output logic [ADDR_W-1:0]   memAddr,
  input  logic                memWrAck,
  output logic                memBurstDone,
  output logic [BEAT_W-1:0]   memWrData
);

  ctlStrobe_t strobe;

  burstWriteCtrl u_ctrl (
    .clk               (clk),
    .rst               (rst),
    .reqValid          (reqValid),
    .memInitDone       (memInitDone),
    .memCmdBusy        (memCmdBusy),
    .memRefreshPending (memRefreshPending),
    .memWrAck          (memWrAck),
    .memWrCmd          (memWrCmd),
    .memBurstDone      (memBurstDone),
    .busy              (busy),
    .done              (done),
    .strobe            (strobe)
  );

  burstWriteData #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .memAddr   (memAddr),
    .memWrData (memWrData)
  );

endmodule

// File: rtl/burstWriteChecker.sv
module burstWriteChecker #(
  parameter int ADDR_W = 27,
  parameter int BEAT_W = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                reqValid,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic                busy,
  input logic                done,
  input logic                memInitDone,
  input logic                memCmdBusy,
  input logic                memRefreshPending,
  input logic                memWrCmd,
  input logic [ADDR_W-1:0]   memAddr,
  input logic                memWrAck,
  input logic                memBurstDone,
  input logic [BEAT_W-1:0]   memWrData
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy && !done && !memWrCmd && !memBurstDone && memWrData == '0));

  p_gate_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(memInitDone && !memCmdBusy && !memRefreshPending)) |=> !busy);

  p_cmd_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (memWrCmd && memAddr == $past(reqAddr)));

  p_cmd_wait_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (memWrCmd && !memWrAck && memWrData == '0 && !$past(memWrCmd)) |=> memWrCmd);

  p_burst_pair_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(memBurstDone) |=> memBurstDone);

  p_burst_end_r5: assert property (@(posedge clk) disable iff (rst)
    (memBurstDone && $past(memBurstDone)) |=> !memBurstDone);

  p_burst_no_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    memBurstDone |-> !memWrCmd);

  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && reqValid) |=> done);

  p_active_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (memWrCmd || memBurstDone || done) |-> busy);

  p_addr_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(memAddr));

endmodule

bind burstWriteSeq burstWriteChecker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk               (clk),
  .rst               (rst),
  .reqValid          (reqValid),
  .reqAddr           (reqAddr),
  .busy              (busy),
  .done              (done),
  .memInitDone       (memInitDone),
  .memCmdBusy        (memCmdBusy),
  .memRefreshPending (memRefreshPending),
  .memWrCmd          (memWrCmd),
  .memAddr           (memAddr),
  .memWrAck          (memWrAck),
  .memBurstDone      (memBurstDone),
  .memWrData         (memWrData)
);

// File: tb/test_burstWriteSeq.sv
`timescale 1ns/1ps
module test_burstWriteSeq;

  localparam int ADDR_W = 27;
  localparam int BEAT_W = 64;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                reqValid = 1'b0;
  logic [ADDR_W-1:0]   reqAddr = '0;
  logic [2*BEAT_W-1:0] reqData = '0;
  logic                busy, done;
  logic                memInitDone = 1'b1;
  logic                memCmdBusy = 1'b0;
  logic                memRefreshPending = 1'b0;
  logic                memWrCmd;
  logic [ADDR_W-1:0]   memAddr;
  logic                memWrAck = 1'b0;
  logic                memBurstDone;
  logic [BEAT_W-1:0]   memWrData;

  int nTests = 0;
  int nFail  = 0;

  always #2 clk = ~clk;  // 250 MHz

  burstWriteSeq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_burstWriteSeq (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr), .reqData(reqData),
    .busy(busy), .done(done), .memInitDone(memInitDone), .memCmdBusy(memCmdBusy),
    .memRefreshPending(memRefreshPending), .memWrCmd(memWrCmd), .memAddr(memAddr),
    .memWrAck(memWrAck), .memBurstDone(memBurstDone), .memWrData(memWrData)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkCtl(input string tag, input logic eBusy, input logic eCmd,
                          input logic eBd, input logic eDone);
    check(busy == eBusy, {tag, " busy"}, 128'(busy), 128'(eBusy));
    check(memWrCmd == eCmd, {tag, " memWrCmd"}, 128'(memWrCmd), 128'(eCmd));
    check(memBurstDone == eBd, {tag, " memBurstDone"}, 128'(memBurstDone), 128'(eBd));
    check(done == eDone, {tag, " done"}, 128'(done), 128'(eDone));
  endtask

  // Assumes the current negedge is the first cycle of the command phase.
  task automatic runFromIssue(input logic [ADDR_W-1:0] eAddr, input logic [127:0] eWord,
                              input int ackDelay, input int holdCycles);
    checkCtl("R3 issue", 1, 1, 0, 0);
    check(memAddr == eAddr, "R3 address", 128'(memAddr), 128'(eAddr));
    check(memWrData == '0, "R9 idle data in issue", 128'(memWrData), 0);
    for (int k = 0; k < ackDelay; k++) begin
      @(negedge clk);
      check(memWrCmd == 1'b1, "R3 command held before ack", 128'(memWrCmd), 1);
    end
    memWrAck = 1'b1;
    @(negedge clk);
    memWrAck = 1'b0;
    checkCtl("R4 beat1", 1, 1, 0, 0);
    check(memWrData == eWord[63:0], "R4 low half", 128'(memWrData), 128'(eWord[63:0]));
    check(memAddr == eAddr, "R8 address stable", 128'(memAddr), 128'(eAddr));
    @(negedge clk);
    checkCtl("R4 beat2", 1, 1, 0, 0);
    check(memWrData == eWord[127:64], "R4 high half", 128'(memWrData), 128'(eWord[127:64]));
    @(negedge clk);
    checkCtl("R5 fin1", 1, 0, 1, 0);
    check(memWrData == '0, "R9 data zero fin1", 128'(memWrData), 0);
    @(negedge clk);
    checkCtl("R5 fin2", 1, 0, 1, 0);
    @(negedge clk);
    checkCtl("R6 end", 1, 0, 0, 1);
    check(memWrData == '0, "R9 data zero end", 128'(memWrData), 0);
    for (int k = 0; k < holdCycles; k++) begin
      @(negedge clk);
      checkCtl("R6 end held", 1, 0, 0, 1);
    end
    reqValid = 1'b0;
    @(negedge clk);
    checkCtl("R6 R7 back to idle", 0, 0, 0, 0);
  endtask

  task automatic testReset();
    checkCtl("R1 reset", 0, 0, 0, 0);
    check(memWrData == '0, "R1 reset data", 128'(memWrData), 0);
  endtask

  task automatic testBasic();
    logic [127:0] w = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    reqAddr = 27'h0abcdef; reqData = w; reqValid = 1'b1;
    @(negedge clk);
    runFromIssue(27'h0abcdef, w, 0, 0);
  endtask

  task automatic testGate(input int which);
    logic [127:0] w = {64'hAAAA_0000_0000_0000 | 64'(which), 64'h5555_0000_0000_0000 | 64'(which)};
    memInitDone       = (which != 0);
    memCmdBusy        = (which == 1);
    memRefreshPending = (which == 2);
    reqAddr = 27'(100 + which); reqData = w; reqValid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checkCtl("R2 blocked", 0, 0, 0, 0);
    end
    memInitDone = 1'b1; memCmdBusy = 1'b0; memRefreshPending = 1'b0;
    @(negedge clk);
    runFromIssue(27'(100 + which), w, 1, 0);
  endtask

  task automatic testLateAckChange();
    logic [127:0] w = 128'hdead_beef_0000_1111_2222_3333_cafe_f00d;
    reqAddr = 27'h1234567; reqData = w; reqValid = 1'b1;
    @(negedge clk);
    // client changes its inputs after acceptance
    reqAddr = 27'h7654321; reqData = ~w;
    runFromIssue(27'h1234567, w, 4, 3);
  endtask

  task automatic testBackToBack();
    logic [127:0] w1 = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    logic [127:0] w2 = 128'h9999_aaaa_bbbb_cccc_dddd_eeee_ffff_0000;
    reqAddr = 27'h11; reqData = w1; reqValid = 1'b1;
    @(negedge clk);
    runFromIssue(27'h11, w1, 0, 1);
    reqAddr = 27'h22; reqData = w2; reqValid = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R7 second accept after idle", 128'(busy), 1);
    runFromIssue(27'h22, w2, 2, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testBasic();
    for (int g = 0; g < 3; g++) testGate(g);
    testLateAckChange();
    testBackToBack();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule